// File: doc/BRIEF.md
# Asynchronous Serial Frame Transmitter

This block turns parallel data words into asynchronous serial frames on a single line. Each frame is a low start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity bit, then one or more high stop bits. Between frames the line rests high. The baud timing comes from an internal down-counter. It divides the system clock by a 16-bit divisor and gives sixteen ticks per bit.

Software-side logic offers a word with a one-cycle write strobe. The word sits in a one-entry holding register until the shift engine is free. A second word can therefore be queued while the first is on the line, and the two frames then follow each other with no gap. The line-control inputs are sampled when a word moves from the holding register into the shift engine:

- word length
- parity enable
- parity sense
- stick parity
- stop-bit count

A break input forces the line low for as long as it is held. It takes effect immediately and overrides any frame in progress.

Top module: `async_frame_tx`

## Requirements
- R1: After reset, and whenever the block is idle with break low, `txd` is 1, and `hold_empty` and `tx_idle` are both 1.
- R2: Every frame starts with one start bit at 0 and ends with stop bits at 1. Each start, data and parity bit lasts exactly 16 ticks.
- R3: `word_len` selects how many data bits are sent: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Bits go out from `wr_data[0]` upward.
- R4: With `parity_en`=1 and `stick_par`=0, a parity bit follows the last data bit and comes before the stop bits. With `even_sel`=1 the count of ones over the data bits plus the parity bit is even. With `even_sel`=0 that count is odd.
- R5: With `parity_en`=1 and `stick_par`=1, the parity bit does not depend on the data. It is 0 when `even_sel`=1 and 1 when `even_sel`=0.
- R6: With `stop_sel`=0 the stop part lasts 16 ticks. With `stop_sel`=1 it lasts 24 ticks for 5-bit words and 32 ticks for 6-, 7- and 8-bit words.
- R7: A word queued in the holding register starts its start bit on the tick right after the previous frame's last stop tick. The spacing from one start edge to the next therefore equals the frame length exactly.
- R8: While `brk` is 1, `txd` is 0 from the next clock edge on, even in the middle of a frame. After `brk` clears and the block goes idle, `txd` is 1 again.
- R9: One clock after a write, `hold_empty` is 0. It returns to 1 as soon as the shift engine takes the word, even while a frame is still being sent. `tx_idle` is 1 only when the holding register is empty and no frame is on the line.
- R10: A tick occurs once every `divisor` clock cycles. A divisor of 0 behaves as 1, so there is one tick per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| divisor | input | 16 | Clock cycles per tick (0 treated as 1) |
| wr_valid | input | 1 | Write strobe that loads `wr_data` into the holding register |
| wr_data | input | 8 | Data word to send |
| word_len | input | 2 | Data width select (00=5 bits up to 11=8 bits) |
| parity_en | input | 1 | Adds a parity bit to the frame |
| even_sel | input | 1 | Parity sense: 1 even, 0 odd |
| stick_par | input | 1 | Makes the parity bit a constant |
| stop_sel | input | 1 | 0: one stop bit; 1: 1.5 or 2 stop bits |
| brk | input | 1 | Holds the line at 0 while set |
| txd | output | 1 | Serial output line |
| hold_empty | output | 1 | Holding register can accept a word |
| tx_idle | output | 1 | Holding register and shift engine are both empty |

## Verification
The bench queues three words back to back for each line setting. It decodes the first frame at mid-bit and times the start edges of the second and third frames. A wrong stop length (for example 2 stop bits on 5-bit words, or 1.5 stop bits on longer words) or a one-clock gap between queued frames shows up as a wrong spacing. That gap is most visible with a divisor of 0, where each tick is one clock. Inverted parity sense, a stick-parity constant of the wrong polarity, or a parity bit computed over unused high data bits each produce a wrong parity sample. A break raised mid-frame must hold the line low beyond one full frame. Flags that follow the shift engine instead of the holding register show up at the first clocks after a write.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic [1:0] wlen;
    logic       pen;
    logic       eps;
    logic       stick;
    logic       stb;
  } line_cfg_t;

  function automatic logic [3:0] word_bits(input logic [1:0] wlen);
    return 4'd5 + {2'b00, wlen};
  endfunction

endpackage

// File: rtl/async_tx_baud.sv
module async_tx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d, eff_div;

  always_comb begin
    eff_div = (divisor == '0) ? DIV_W'(1) : divisor;
    tick    = (cnt_q <= DIV_W'(1));
    cnt_d   = tick ? eff_div : (cnt_q - DIV_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R10: with a steady divisor above one, ticks never come on adjacent clocks
  assert_tick_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && divisor > DIV_W'(1) && $stable(divisor)) |=> !tick);

endmodule

// File: rtl/async_tx_hold.sv
module async_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);

  logic              full_d;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    full_d = full;
    data_d = data;
    if (take)     full_d = 1'b0;
    if (wr_valid) begin
      full_d = 1'b1;
      data_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      full <= full_d;
      if (wr_valid) data <= data_d;
    end
  end

  // R9: a word taken by the shift engine frees the holder on the next clock
  assert_take_frees_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !wr_valid) |=> !full);

endmodule

// File: rtl/async_tx_shift.sv
module async_tx_shift
  import async_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  line_cfg_t         cfg_in,
  output logic              take,
  output logic              busy,
  output logic              line_bit
);

  localparam int TC_W = $clog2(2 * OVS + 1);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [TC_W-1:0] LIM_ONE  = TC_W'(OVS);
  localparam logic [TC_W-1:0] LIM_HALF = TC_W'((3 * OVS) / 2);
  localparam logic [TC_W-1:0] LIM_TWO  = TC_W'(2 * OVS);

  tx_state_e         state_q, state_d;
  logic [DATA_W-1:0] sreg_q, sreg_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [TC_W-1:0]   tcnt_q, tcnt_d, bit_limit;
  logic              par_q, par_d;
  line_cfg_t         cfg_q, cfg_d;
  logic [3:0]        nbits_in, nbits_q;
  logic [DATA_W-1:0] in_mask;
  logic              ones_odd, par_new, bit_end;

  always_comb begin
    nbits_in = word_bits(cfg_in.wlen);
    nbits_q  = word_bits(cfg_q.wlen);
    in_mask  = {DATA_W{1'b1}} >> (DATA_W - int'(nbits_in));
    ones_odd = ^(hold_data & in_mask);
    if (cfg_in.stick) par_new = ~cfg_in.eps;
    else              par_new = cfg_in.eps ? ones_odd : ~ones_odd;
  end

  always_comb begin
    bit_limit = LIM_ONE;
    if (state_q == ST_STOP && cfg_q.stb)
      bit_limit = (cfg_q.wlen == 2'b00) ? LIM_HALF : LIM_TWO;
    bit_end = tick && (tcnt_q == bit_limit - TC_W'(1));
  end

  always_comb begin
    state_d = state_q;
    sreg_d  = sreg_q;
    idx_d   = idx_q;
    tcnt_d  = tcnt_q;
    par_d   = par_q;
    cfg_d   = cfg_q;
    take    = 1'b0;
    if (state_q == ST_IDLE) begin
      take = hold_full;
    end else if (tick) begin
      if (!bit_end) begin
        tcnt_d = tcnt_q + TC_W'(1);
      end else begin
        tcnt_d = '0;
        unique case (state_q)
          ST_START: begin
            state_d = ST_DATA;
            idx_d   = '0;
          end
          ST_DATA: begin
            sreg_d = sreg_q >> 1;
            idx_d  = idx_q + IDX_W'(1);
            if ({1'b0, idx_q} == (nbits_q - 4'd1))
              state_d = cfg_q.pen ? ST_PAR : ST_STOP;
          end
          ST_PAR:  state_d = ST_STOP;
          ST_STOP: begin
            take    = hold_full;
            state_d = ST_IDLE;
          end
          default: state_d = ST_IDLE;
        endcase
      end
    end
    if (take) begin
      state_d = ST_START;
      sreg_d  = hold_data;
      par_d   = par_new;
      cfg_d   = cfg_in;
      idx_d   = '0;
      tcnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sreg_q  <= '0;
      idx_q   <= '0;
      tcnt_q  <= '0;
      par_q   <= 1'b0;
      cfg_q   <= '0;
    end else begin
      state_q <= state_d;
      sreg_q  <= sreg_d;
      idx_q   <= idx_d;
      tcnt_q  <= tcnt_d;
      par_q   <= par_d;
      cfg_q   <= cfg_d;
    end
  end

  always_comb begin
    busy = (state_q != ST_IDLE);
    unique case (state_q)
      ST_START: line_bit = 1'b0;
      ST_DATA:  line_bit = sreg_q[0];
      ST_PAR:   line_bit = par_q;
      default:  line_bit = 1'b1;
    endcase
  end

  // R3: the data index stays inside the selected word length
  assert_data_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA) |-> ({1'b0, idx_q} < nbits_q));

  // R6: the tick counter never runs past the length of the current bit
  assert_tick_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |-> (tcnt_q < bit_limit));

endmodule

// File: rtl/async_frame_tx.sv
module async_frame_tx
  import async_tx_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        word_len,
  input  logic              parity_en,
  input  logic              even_sel,
  input  logic              stick_par,
  input  logic              stop_sel,
  input  logic              brk,
  output logic              txd,
  output logic              hold_empty,
  output logic              tx_idle
);

  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  logic              tick, take, busy, line_bit, hold_full, txd_d;
  logic [DATA_W-1:0] hold_data;
  line_cfg_t         cfg_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  always_comb begin
    cfg_in.wlen  = word_len;
    cfg_in.pen   = parity_en;
    cfg_in.eps   = even_sel;
    cfg_in.stick = stick_par;
    cfg_in.stb   = stop_sel;
  end

  async_tx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .divisor (divisor),
    .tick    (tick)
  );

  async_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .wr_valid (wr_valid),
    .wr_data  (wr_data),
    .take     (take),
    .full     (hold_full),
    .data     (hold_data)
  );

  async_tx_shift #(.DATA_W(DATA_W), .OVS(OVS)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .tick      (tick),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .cfg_in    (cfg_in),
    .take      (take),
    .busy      (busy),
    .line_bit  (line_bit)
  );

  assign txd_d = brk ? 1'b0 : line_bit;

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) txd <= 1'b1;
    else            txd <= txd_d;
  end

  assign hold_empty = ~hold_full;
  assign tx_idle    = ~hold_full & ~busy;

  // R8: a break request forces space on the line at the next edge
  assert_break_space_R8: assert property (@(posedge clk) disable iff (!rst_n_int)
    brk |=> !txd);

  // R1: an idle transmitter without break keeps the line at mark
  assert_idle_mark_R1: assert property (@(posedge clk) disable iff (!rst_n_int)
    (tx_idle && !brk) |=> txd);

endmodule

// File: tb/async_frame_tx_test.sv
module async_frame_tx_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] divisor = 16'd3;
  logic        wr_valid = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic [1:0]  word_len = 2'b11;
  logic        parity_en = 1'b0, even_sel = 1'b0, stick_par = 1'b0, stop_sel = 1'b0, brk = 1'b0;
  logic        txd, hold_empty, tx_idle;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  async_frame_tx uut (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .wr_valid(wr_valid), .wr_data(wr_data),
    .word_len(word_len), .parity_en(parity_en), .even_sel(even_sel), .stick_par(stick_par),
    .stop_sel(stop_sel), .brk(brk), .txd(txd), .hold_empty(hold_empty), .tx_idle(tx_idle)
  );

  // {data, wlen, pen, eps, stick, stb, exp_parity, pad, frame_ticks, divisor}
  localparam int NV = 8;
  localparam logic [31:0] VEC [NV] = '{
    {8'hA5, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd160, 8'd3},
    {8'h35, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'd136, 8'd3},
    {8'h3C, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd160, 8'd3},
    {8'h7F, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'd160, 8'd2},
    {8'h00, 2'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'd192, 8'd3},
    {8'hFF, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd176, 8'd2},
    {8'h5A, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd120, 8'd3},
    {8'hC3, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd160, 8'd0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!tx_idle);
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic send_words(input logic [7:0] d, input int n);
    for (int w = 0; w < n; w++) begin
      while (!hold_empty) @(negedge clk);
      wr_data  = d;
      wr_valid = 1'b1;
      @(negedge clk);
      wr_valid = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic run_vec(input int i);
    logic [7:0] d;
    int nb, dv, slot, t0, t1, t2, per;
    string preq;
    d         = VEC[i][31:24];
    word_len  = VEC[i][23:22];
    parity_en = VEC[i][21];
    even_sel  = VEC[i][20];
    stick_par = VEC[i][19];
    stop_sel  = VEC[i][18];
    divisor   = {8'd0, VEC[i][7:0]};
    dv   = (VEC[i][7:0] == 8'd0) ? 1 : int'(VEC[i][7:0]);
    nb   = 5 + int'(VEC[i][23:22]);
    per  = int'(VEC[i][15:8]) * dv;
    preq = VEC[i][19] ? "R5 stick parity" : "R4 parity";
    wait_idle();
    fork
      send_words(d, 3);
      begin
        while (txd) @(negedge clk);
        t0 = cyc;
        slot = 0;
        wait_until(t0 + 8 * dv);
        chk($sformatf("R2 start bit v%0d", i), int'(txd), 0);
        for (int k = 0; k < nb; k++) begin
          slot++;
          wait_until(t0 + 8 * dv + 16 * dv * slot);
          chk($sformatf("R3 data bit %0d v%0d", k, i), int'(txd), int'(d[k]));
        end
        if (parity_en) begin
          slot++;
          wait_until(t0 + 8 * dv + 16 * dv * slot);
          chk($sformatf("%s v%0d", preq, i), int'(txd), int'(VEC[i][17]));
        end
        slot++;
        wait_until(t0 + 8 * dv + 16 * dv * slot);
        chk($sformatf("R2 stop bit v%0d", i), int'(txd), 1);
        while (txd) @(negedge clk);
        t1 = cyc;
        wait_until(t1 + per - 4 * dv);
        while (txd) @(negedge clk);
        t2 = cyc;
        chk($sformatf("R6 R7 R10 frame spacing v%0d", i), t2 - t1, per);
      end
    join
    wait_idle();
  endtask

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wait_cycles(4);
    rst_n = 1'b1;
    wait_cycles(6);
    // R1: reset state
    chk("R1 reset txd", int'(txd), 1);
    chk("R1 reset hold_empty", int'(hold_empty), 1);
    chk("R1 reset tx_idle", int'(tx_idle), 1);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R9: flag timing around a write and a queued word
    divisor = 16'd3; word_len = 2'b11; parity_en = 1'b0; stop_sel = 1'b0;
    wait_idle();
    wr_data = 8'h11; wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    chk("R9 hold_empty after write", int'(hold_empty), 0);
    chk("R9 tx_idle after write", int'(tx_idle), 0);
    @(negedge clk);
    chk("R9 hold_empty after transfer", int'(hold_empty), 1);
    chk("R9 tx_idle while sending", int'(tx_idle), 0);
    wr_data = 8'h22; wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    chk("R9 hold_empty with queued word", int'(hold_empty), 0);
    while (!hold_empty) @(negedge clk);
    chk("R9 tx_idle while second frame sends", int'(tx_idle), 0);
    wait_idle();
    wait_cycles(2);
    chk("R1 idle line mark", int'(txd), 1);

    // R8: break in the middle of a frame
    begin
      int bad;
      bad = 0;
      wr_data = 8'hFF; wr_valid = 1'b1;
      @(negedge clk);
      wr_valid = 1'b0;
      wait_cycles(100);
      brk = 1'b1;
      wait_cycles(2);
      for (int k = 0; k < 600; k++) begin
        if (txd !== 1'b0) bad++;
        @(negedge clk);
      end
      chk("R8 break holds space", bad, 0);
      brk = 1'b0;
      wait_idle();
      wait_cycles(2);
      chk("R8 line mark after break", int'(txd), 1);
    end

    // R8: break from idle
    brk = 1'b1;
    wait_cycles(2);
    chk("R8 break from idle", int'(txd), 0);
    brk = 1'b0;
    wait_cycles(2);
    chk("R8 release from idle", int'(txd), 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule